// File: doc/BRIEF.md
# Reset and Wake Cause Status Tracker

This block holds the sticky status bits that firmware reads after start-up to learn why the processor last left reset or sleep. Three flags work together: a power-on marker, a time-out flag and a power-down flag. Their combined value tells a watchdog reset from a watchdog wake-up, and a reset-pin event from a wake-up out of sleep. A fourth flag records a low-supply condition. Hardware clears it whenever the supply comparator trips, and only software can set it again.

Event inputs are single-cycle pulses in the block clock domain. They cover watchdog time-out, the external reset pin, interrupt wake-up, sleep entry and the clear-watchdog instruction. The synchronous reset input is the power-on reset. The low-supply trip input comes from an analog comparator and passes through a parameterised synchronizer. A register-style write port lets software change the power-on marker and the low-supply flag. The block keeps an internal asleep state, so each event is interpreted according to whether the core was running or sleeping. All outputs are registered, and the decoded cause code is registered in the same cycle as the flags it describes.

Top module: `rst_cause_tracker`

## Requirements
- R1: While rst is high at a clock edge, the flags become por=0, to=1, pd=1, lv=0, the cause becomes 0 (power-on) and the core is considered awake.
- R2: sleep_enter_i while awake gives to=1 and pd=0 and puts the core asleep. While asleep, sleep_enter_i has no effect.
- R3: clr_wdt_i while awake gives to=1 and pd=1. While asleep, clr_wdt_i has no effect.
- R4: wdt_timeout_i while awake gives to=0 and pd=1, which is cause 1 (watchdog reset) when por=1.
- R5: wdt_timeout_i while asleep gives to=0 and pd=0 and wakes the core, which is cause 2 (watchdog wake) when por=1.
- R6: pin_reset_i while awake gives to=1 and pd=1 (cause 3, pin reset). While asleep it gives to=1 and pd=0 and wakes the core (cause 4, sleep wake).
- R7: irq_wake_i while asleep gives to=1 and pd=0 and wakes the core. While awake it has no effect.
- R8: Among the events that take effect in the current state, only the highest one is applied in a cycle. The order is watchdog, then pin reset, then interrupt wake, then sleep entry, then clear-watchdog.
- R9: When sw_we_i is high, sw_wdata_i bit 0 is loaded into por and bit 3 into lv. Bits 1 (to) and 2 (pd) are ignored. Events never change por.
- R10: A high lv_trip_i clears lv once it has passed through LV_SYNC_STAGES synchronizer flops, and this clear overrides a software set in the same cycle.
- R11: The cause code depends on {por,to,pd}. 011 gives 0, 101 gives 1, 100 gives 2, 111 gives 3 and 110 gives 4. Any value with por=0 and either to=0 or pd=0 gives 5 (illegal).
- R12: Flags and cause change on the clock edge that samples the event or write, and cause always matches the flags shown in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| wdt_timeout_i | input | 1 | Watchdog time-out pulse |
| pin_reset_i | input | 1 | External reset pin event pulse |
| irq_wake_i | input | 1 | Interrupt wake-up pulse |
| sleep_enter_i | input | 1 | Sleep instruction pulse |
| clr_wdt_i | input | 1 | Clear-watchdog instruction pulse |
| lv_trip_i | input | 1 | Asynchronous low-supply comparator output, high when tripped |
| sw_we_i | input | 1 | Software write strobe |
| sw_wdata_i | input | 4 | Write data: bit0 por, bit1 to (ignored), bit2 pd (ignored), bit3 lv |
| por_flag_o | output | 1 | Power-on marker, 0 after power-on |
| to_flag_o | output | 1 | Time-out flag, 0 after a watchdog time-out |
| pd_flag_o | output | 1 | Power-down flag, 0 after sleep entry |
| lv_flag_o | output | 1 | Low-supply flag, 0 after a trip |
| cause_o | output | 3 | Decoded cause code |

## Verification
The bench builds the block with LV_SYNC_STAGES at its default of 2. With that value, a trip pulse reaches the low-supply flag on the third edge after it is sampled, so the bench can check the window in which a software set still holds before the hardware clear. Driving software writes of por=0 and then sleep or watchdog events brings every illegal combination within reach of the decoder.

// File: rtl/rc_pkg.sv
package rc_pkg;

  typedef enum logic [2:0] {
    CAUSE_POWER_ON   = 3'd0,
    CAUSE_WDT_RESET  = 3'd1,
    CAUSE_WDT_WAKE   = 3'd2,
    CAUSE_PIN_RESET  = 3'd3,
    CAUSE_SLEEP_WAKE = 3'd4,
    CAUSE_ILLEGAL    = 3'd5
  } cause_e;

  // bit order matches the software write word
  typedef struct packed {
    logic lv;
    logic pd;
    logic to;
    logic por;
  } flags_t;

  localparam int WR_W  = $bits(flags_t);
  localparam int WB_POR = 0;
  localparam int WB_TO  = 1;
  localparam int WB_PD  = 2;
  localparam int WB_LV  = 3;

  localparam flags_t FLAGS_AT_POWER_ON = '{lv: 1'b0, pd: 1'b1, to: 1'b1, por: 1'b0};

endpackage

// File: rtl/rc_sync.sv
module rc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign q = d;
    end else begin : g_chain
      logic [STAGES-1:0] stage_q;
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
          always_ff @(posedge clk) begin
            if (rst) stage_q[0] <= 1'b0;
            else     stage_q[0] <= d;
          end
        end else begin : g_next
          always_ff @(posedge clk) begin
            if (rst) stage_q[i] <= 1'b0;
            else     stage_q[i] <= stage_q[i-1];
          end
        end
      end
      assign q = stage_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/rc_flag_ctrl.sv
module rc_flag_ctrl
  import rc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            wdt_to,
  input  logic            pin_rst,
  input  logic            irq_wake,
  input  logic            sleep_req,
  input  logic            clrwdt,
  input  logic            sw_we,
  input  logic [WR_W-1:0] sw_wdata,
  input  logic            lv_trip_s,
  output flags_t          flags_q,
  output flags_t          flags_d
);

  logic asleep_q, asleep_d;

  always_comb begin
    flags_d  = flags_q;
    asleep_d = asleep_q;
    // one event per cycle, highest effective one wins
    if (wdt_to) begin
      flags_d.to = 1'b0;
      flags_d.pd = !asleep_q;
      asleep_d   = 1'b0;
    end else if (pin_rst) begin
      flags_d.to = 1'b1;
      flags_d.pd = !asleep_q;
      asleep_d   = 1'b0;
    end else if (irq_wake && asleep_q) begin
      flags_d.to = 1'b1;
      flags_d.pd = 1'b0;
      asleep_d   = 1'b0;
    end else if (sleep_req && !asleep_q) begin
      flags_d.to = 1'b1;
      flags_d.pd = 1'b0;
      asleep_d   = 1'b1;
    end else if (clrwdt && !asleep_q) begin
      flags_d.to = 1'b1;
      flags_d.pd = 1'b1;
    end
    if (sw_we) begin
      flags_d.por = sw_wdata[WB_POR];
      flags_d.lv  = sw_wdata[WB_LV];
    end
    if (lv_trip_s) flags_d.lv = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q  <= FLAGS_AT_POWER_ON;
      asleep_q <= 1'b0;
    end else begin
      flags_q  <= flags_d;
      asleep_q <= asleep_d;
    end
  end

  // R1
  a_r1_power_on_state: assert property (@(posedge clk)
    rst |=> (flags_q == FLAGS_AT_POWER_ON && !asleep_q));

  // R4, R5
  a_r4_wdt_clears_to: assert property (@(posedge clk) disable iff (rst)
    wdt_to |=> !flags_q.to);

  // R2
  a_r2_sleep_clears_pd: assert property (@(posedge clk) disable iff (rst)
    (sleep_req && !asleep_q && !wdt_to && !pin_rst) |=> (!flags_q.pd && flags_q.to && asleep_q));

  // R7
  a_r7_irq_awake_no_effect: assert property (@(posedge clk) disable iff (rst)
    (irq_wake && !asleep_q && !wdt_to && !pin_rst && !sleep_req && !clrwdt)
      |=> ($stable(flags_q.to) && $stable(flags_q.pd)));

  // R9
  a_r9_por_holds_without_write: assert property (@(posedge clk) disable iff (rst)
    !sw_we |=> $stable(flags_q.por));

  a_r9_ro_bits_ignored: assert property (@(posedge clk) disable iff (rst)
    (sw_we && !wdt_to && !pin_rst && !irq_wake && !sleep_req && !clrwdt &&
     (sw_wdata[WB_TO] != flags_q.to || sw_wdata[WB_PD] != flags_q.pd))
      |=> ($stable(flags_q.to) && $stable(flags_q.pd)));

  // R10
  a_r10_trip_clears_lv: assert property (@(posedge clk) disable iff (rst)
    lv_trip_s |=> !flags_q.lv);

endmodule

// File: rtl/rc_cause_dec.sv
module rc_cause_dec
  import rc_pkg::*;
(
  input  flags_t flags,
  output cause_e cause
);

  always_comb begin
    case ({flags.por, flags.to, flags.pd})
      3'b011:  cause = CAUSE_POWER_ON;
      3'b101:  cause = CAUSE_WDT_RESET;
      3'b100:  cause = CAUSE_WDT_WAKE;
      3'b111:  cause = CAUSE_PIN_RESET;
      3'b110:  cause = CAUSE_SLEEP_WAKE;
      default: cause = CAUSE_ILLEGAL;
    endcase
  end

endmodule

// File: rtl/rst_cause_tracker.sv
module rst_cause_tracker
  import rc_pkg::*;
#(
  parameter int LV_SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wdt_timeout_i,
  input  logic            pin_reset_i,
  input  logic            irq_wake_i,
  input  logic            sleep_enter_i,
  input  logic            clr_wdt_i,
  input  logic            lv_trip_i,
  input  logic            sw_we_i,
  input  logic [WR_W-1:0] sw_wdata_i,
  output logic            por_flag_o,
  output logic            to_flag_o,
  output logic            pd_flag_o,
  output logic            lv_flag_o,
  output logic [2:0]      cause_o
);

  logic   lv_trip_s;
  flags_t flags_q, flags_d;
  cause_e cause_d, cause_q;

  rc_sync #(.STAGES(LV_SYNC_STAGES)) u_lv_sync (
    .clk (clk),
    .rst (rst),
    .d   (lv_trip_i),
    .q   (lv_trip_s)
  );

  rc_flag_ctrl u_flags (
    .clk       (clk),
    .rst       (rst),
    .wdt_to    (wdt_timeout_i),
    .pin_rst   (pin_reset_i),
    .irq_wake  (irq_wake_i),
    .sleep_req (sleep_enter_i),
    .clrwdt    (clr_wdt_i),
    .sw_we     (sw_we_i),
    .sw_wdata  (sw_wdata_i),
    .lv_trip_s (lv_trip_s),
    .flags_q   (flags_q),
    .flags_d   (flags_d)
  );

  // decode next-state flags so cause lands in the same cycle as the flags
  rc_cause_dec u_dec (
    .flags (flags_d),
    .cause (cause_d)
  );

  always_ff @(posedge clk) begin
    if (rst) cause_q <= CAUSE_POWER_ON;
    else     cause_q <= cause_d;
  end

  assign por_flag_o = flags_q.por;
  assign to_flag_o  = flags_q.to;
  assign pd_flag_o  = flags_q.pd;
  assign lv_flag_o  = flags_q.lv;
  assign cause_o    = cause_q;

  // R11
  a_r11_illegal_flagged: assert property (@(posedge clk) disable iff (rst)
    (!por_flag_o && !(to_flag_o && pd_flag_o)) |-> (cause_o == CAUSE_ILLEGAL));

  a_r11_power_on_code: assert property (@(posedge clk) disable iff (rst)
    (!por_flag_o && to_flag_o && pd_flag_o) |-> (cause_o == CAUSE_POWER_ON));

  // R1
  a_r1_cause_after_reset: assert property (@(posedge clk)
    rst |=> (cause_o == CAUSE_POWER_ON));

endmodule

// File: tb/rst_cause_tracker_tb.sv
module rst_cause_tracker_tb;

  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wdt = 1'b0, pin = 1'b0, irq = 1'b0, slp = 1'b0, clr = 1'b0, trip = 1'b0, we = 1'b0;
  logic [3:0] wd = 4'd0;
  logic por_o, to_o, pd_o, lv_o;
  logic [2:0] cause_o;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  // model state
  logic m_por, m_to, m_pd, m_lv, m_sleep;
  logic [SYNC-1:0] m_pipe;

  always #2 clk = ~clk;

  rst_cause_tracker #(.LV_SYNC_STAGES(SYNC)) u_dut (
    .clk (clk), .rst (rst),
    .wdt_timeout_i (wdt), .pin_reset_i (pin), .irq_wake_i (irq),
    .sleep_enter_i (slp), .clr_wdt_i (clr), .lv_trip_i (trip),
    .sw_we_i (we), .sw_wdata_i (wd),
    .por_flag_o (por_o), .to_flag_o (to_o), .pd_flag_o (pd_o),
    .lv_flag_o (lv_o), .cause_o (cause_o)
  );

  function automatic logic [2:0] exp_cause(input logic p, input logic t, input logic d);
    if (!p && t && d) return 3'd0;
    if (!p)           return 3'd5;
    if (!t && d)      return 3'd1;
    if (!t && !d)     return 3'd2;
    if (t && d)       return 3'd3;
    return 3'd4;
  endfunction

  task automatic model_reset();
    m_por = 1'b0; m_to = 1'b1; m_pd = 1'b1; m_lv = 1'b0; m_sleep = 1'b0; m_pipe = '0;
  endtask

  task automatic model_step();
    logic ts;
    ts = m_pipe[SYNC-1];
    if (wdt) begin
      m_to = 1'b0; m_pd = !m_sleep; m_sleep = 1'b0;
    end else if (pin) begin
      m_to = 1'b1; m_pd = !m_sleep; m_sleep = 1'b0;
    end else if (irq && m_sleep) begin
      m_to = 1'b1; m_pd = 1'b0; m_sleep = 1'b0;
    end else if (slp && !m_sleep) begin
      m_to = 1'b1; m_pd = 1'b0; m_sleep = 1'b1;
    end else if (clr && !m_sleep) begin
      m_to = 1'b1; m_pd = 1'b1;
    end
    if (we) begin m_por = wd[0]; m_lv = wd[3]; end
    if (ts) m_lv = 1'b0;
    m_pipe = {m_pipe[SYNC-2:0], trip};
  endtask

  task automatic check(input string req);
    logic [6:0] act, exp;
    act = {por_o, to_o, pd_o, lv_o, cause_o};
    exp = {m_por, m_to, m_pd, m_lv, exp_cause(m_por, m_to, m_pd)};
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {por,to,pd,lv,cause} actual %b expected %b", req, act, exp);
    end
  endtask

  // drive inputs away from the edge, advance one edge, then compare
  task automatic cyc(input logic a_wdt, input logic a_pin, input logic a_irq,
                     input logic a_slp, input logic a_clr, input logic a_trip,
                     input logic a_we, input logic [3:0] a_wd, input string req);
    wdt = a_wdt; pin = a_pin; irq = a_irq; slp = a_slp; clr = a_clr;
    trip = a_trip; we = a_we; wd = a_wd;
    @(posedge clk);
    if (rst) model_reset(); else model_step();
    #1;
    check(req);
  endtask

  task automatic idle(input string req);
    cyc(0, 0, 0, 0, 0, trip, 0, 4'd0, req);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    cyc(0, 0, 0, 0, 0, 0, 0, 4'd0, "R1");
    rst = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    #1;
    do_reset();
    idle("R1");
    // software marks power-on as seen; to/pd bits in the write are ignored
    cyc(0, 0, 0, 0, 0, 0, 1, 4'b0001, "R9");
    cyc(1, 0, 0, 0, 0, 0, 0, 4'd0, "R4");          // 101 -> code 1
    cyc(0, 0, 0, 0, 1, 0, 0, 4'd0, "R3");          // 111
    cyc(0, 0, 0, 1, 0, 0, 0, 4'd0, "R2");          // 110 -> code 4
    cyc(0, 0, 0, 1, 0, 0, 0, 4'd0, "R2");          // asleep: no effect
    cyc(0, 0, 0, 0, 1, 0, 0, 4'd0, "R3");          // asleep: clrwdt ignored
    cyc(0, 0, 1, 0, 0, 0, 0, 4'd0, "R7");          // wake
    cyc(0, 0, 0, 0, 1, 0, 0, 4'd0, "R3");
    cyc(0, 0, 1, 0, 0, 0, 0, 4'd0, "R7");          // awake: no effect
    cyc(0, 0, 0, 1, 0, 0, 0, 4'd0, "R2");
    cyc(1, 0, 0, 0, 0, 0, 0, 4'd0, "R5");          // 100 -> code 2
    cyc(0, 0, 0, 0, 1, 0, 0, 4'd0, "R3");
    cyc(0, 1, 0, 0, 0, 0, 0, 4'd0, "R6");          // 111 -> code 3
    cyc(0, 0, 0, 1, 0, 0, 0, 4'd0, "R2");
    cyc(0, 1, 0, 0, 0, 0, 0, 4'd0, "R6");          // 110 -> code 4
    cyc(1, 1, 1, 1, 1, 0, 0, 4'd0, "R8");          // watchdog wins
    cyc(0, 1, 0, 1, 1, 0, 0, 4'd0, "R8");          // pin wins
    cyc(0, 0, 1, 1, 1, 0, 0, 4'd0, "R8");          // irq ignored awake, sleep wins
    cyc(0, 0, 1, 0, 1, 0, 0, 4'd0, "R8");          // asleep: irq wins over clr
    // illegal combinations
    cyc(0, 0, 0, 0, 0, 0, 1, 4'b0110, "R9");       // por=0, to/pd bits ignored
    cyc(0, 0, 0, 1, 0, 0, 0, 4'd0, "R11");         // 010 illegal
    cyc(1, 0, 0, 0, 0, 0, 0, 4'd0, "R11");         // 000 illegal
    cyc(1, 0, 0, 0, 0, 0, 0, 4'd0, "R11");         // 001 illegal
    cyc(0, 0, 0, 0, 1, 0, 0, 4'd0, "R11");         // 011 power-on code
    // low-supply flag
    cyc(0, 0, 0, 0, 0, 0, 1, 4'b1001, "R9");
    cyc(0, 0, 0, 0, 0, 1, 0, 4'd0, "R10");
    cyc(0, 0, 0, 0, 0, 0, 0, 4'd0, "R10");         // still set in sync
    cyc(0, 0, 0, 0, 0, 0, 0, 4'd0, "R10");         // clears here
    cyc(0, 0, 0, 0, 0, 0, 1, 4'b1001, "R10");      // set again
    cyc(0, 0, 0, 0, 0, 1, 0, 4'd0, "R10");
    cyc(0, 0, 0, 0, 0, 1, 0, 4'd0, "R10");
    cyc(0, 0, 0, 0, 0, 1, 1, 4'b1001, "R10");      // trip overrides set
    cyc(0, 0, 0, 0, 0, 0, 0, 4'd0, "R10");
    cyc(0, 0, 0, 0, 0, 0, 0, 4'd0, "R10");
    cyc(0, 0, 0, 0, 0, 0, 1, 4'b1000, "R10");      // trip gone, set holds
    // reset mid-run with a write pending
    rst = 1'b1;
    cyc(1, 0, 0, 0, 0, 0, 1, 4'b1111, "R1");
    rst = 1'b0;
    // random mix
    for (int i = 0; i < 3000; i++) begin
      rst = (($urandom % 250) == 0);
      cyc(($urandom % 9) == 0, ($urandom % 11) == 0, ($urandom % 5) == 0,
          ($urandom % 5) == 0, ($urandom % 6) == 0, ($urandom % 12) == 0,
          ($urandom % 7) == 0, 4'($urandom), rst ? "R1" : "R12");
    end
    rst = 1'b0;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule